// File: doc/BRIEF.md
# Command Checksum Verifier

This block sits on the receive path of a contactless tag, right after the bit-level line decoder. Each beat it accepts is one decoded byte. The byte comes with a 2-bit error-detection field and a flag that marks it as the command word or as a data byte. The block computes the field the reader should have sent and compares it with the field it received. A match raises a one-cycle `chk_ok` pulse. A mismatch aborts the command under way.

Three other faults abort the command too: a line-coding error, an illegal command encoding and a protection failure. Each arrives on its own input pin. An abort is sticky. Every later beat is dropped until `frame_start` marks the start of a new command.

When an abort happens, the block loads a back-off counter with a pseudo-random length taken from a free-running LFSR. When that counter runs out, the block gives one `backoff_done` pulse, which the transmit side uses to time its later header.

The byte input is a valid/ready stream. `in_ready` is high in every cycle outside reset, so the block never holds back the decoder. While reset is asserted `in_ready` is low, and a source must keep `in_valid` and its payload steady until it sees `in_ready` high. A beat counts as transferred on a rising clock edge where both `in_valid` and `in_ready` are high.

Top module: `ckv_verifier`

## Requirements
- R1: For a data byte (`in_is_cmd`=0), the expected field is the count of set bits in all 8 bits modulo 4, with bit 0 of that count inverted. Bit 1 of `in_chk` is the high bit of the field. If the received field matches, `chk_ok` is high for exactly the one cycle after the transfer edge.
- R2: For the command word (`in_is_cmd`=1), only `in_data[7:2]` enter the count. Bits 1:0 have no effect on the expected field.
- R3: If the received field does not match, `abort` is high from the cycle after the transfer edge, and `chk_ok` stays low.
- R4: If any of `err_line`, `err_illegal` or `err_prot` is high at a clock edge, `abort` is high from the next cycle. This applies even when a matching beat transfers on the same edge, and in that case `chk_ok` stays low.
- R5: `abort` stays high until `frame_start`. While `abort` is high, transferred beats raise no `chk_ok`.
- R6: `frame_start` high at an edge clears `abort` and cancels any pending back-off. A beat that transfers on that same edge is dropped.
- R7: When `abort` rises, `backoff_done` pulses high for exactly one cycle. The pulse comes between MIN_WAIT and MIN_WAIT+2^DELAY_BITS-1 cycles after the first cycle in which `abort` is high (2 to 17 cycles with the default parameters).
- R8: `in_ready` is low while `rst_n` is low and high in every cycle after reset.
- R9: After reset, `abort`, `chk_ok` and `backoff_done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_data | input | 8 | Decoded byte |
| in_chk | input | 2 | Received error-detection field |
| in_is_cmd | input | 1 | Beat is the command word |
| err_line | input | 1 | Line-coding error seen by the decoder |
| err_illegal | input | 1 | Command encoding is not legal |
| err_prot | input | 1 | Protection failure on the addressed area |
| frame_start | input | 1 | Start of a new command, clears abort |
| chk_ok | output | 1 | One-cycle pulse: beat passed the check |
| abort | output | 1 | Sticky: current command is aborted |
| backoff_done | output | 1 | One-cycle pulse: random back-off has expired |

## Verification
The back-off length is the hardest behaviour to observe from the ports, because it depends on LFSR state that no port shows. The stimulus triggers aborts at different moments, so each one sees a different LFSR phase. For each abort it counts the cycles up to `backoff_done` and checks that the count falls inside the allowed window and that the pulse lasts exactly one cycle. A separate case drives `frame_start` while a back-off is still counting and checks that no pulse appears afterwards.

// File: rtl/ckv_pkg.sv
package ckv_pkg;
  localparam int BYTE_W = 8;
  localparam int CHK_W  = 2;
  localparam int CMD_LSB = 2;   // command word: bits below this are fixed, not counted
  typedef logic [CHK_W-1:0]  chk_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ckv_calc.sv
module ckv_calc
  import ckv_pkg::*;
(
  input  byte_t data,
  input  logic  is_cmd,
  output chk_t  expected
);
  logic [BYTE_W-1:0] mask;
  logic [3:0]        ones;

  generate
    for (genvar i = 0; i < BYTE_W; i++) begin : g_mask
      if (i < CMD_LSB) begin : g_lo
        assign mask[i] = data[i] & ~is_cmd;
      end else begin : g_hi
        assign mask[i] = data[i];
      end
    end
  endgenerate

  always_comb begin
    ones = '0;
    for (int i = 0; i < BYTE_W; i++) ones = ones + 4'(mask[i]);
  end

  // count modulo 4, low bit flipped
  assign expected = {ones[1], ~ones[0]};
endmodule

// File: rtl/ckv_lfsr.sv
module ckv_lfsr #(
  parameter int          WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'hB8,
  parameter logic [WIDTH-1:0] SEED = 8'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [WIDTH-1:0] state
);
  always_ff @(posedge clk) begin
    if (!rst_n)        state <= SEED;
    else if (state[0]) state <= (state >> 1) ^ TAPS;
    else               state <= state >> 1;
  end
endmodule

// File: rtl/ckv_backoff.sv
module ckv_backoff #(
  parameter int DELAY_BITS = 4,
  parameter int MIN_WAIT   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  cancel,
  input  logic [DELAY_BITS-1:0] rand_bits,
  output logic                  done
);
  localparam int CNT_W = $clog2(MIN_WAIT + (1 << DELAY_BITS)) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (!rst_n || cancel) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cnt_q <= CNT_W'(MIN_WAIT) + CNT_W'(rand_bits);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q == CNT_W'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ckv_verifier.sv
module ckv_verifier
  import ckv_pkg::*;
#(
  parameter int LFSR_W     = 8,
  parameter int DELAY_BITS = 4,
  parameter int MIN_WAIT   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic [1:0] in_chk,
  input  logic       in_is_cmd,
  input  logic       err_line,
  input  logic       err_illegal,
  input  logic       err_prot,
  input  logic       frame_start,
  output logic       chk_ok,
  output logic       abort,
  output logic       backoff_done
);
  chk_t              expected;
  logic [LFSR_W-1:0] lfsr_state;
  logic              accept, fault, set_abort;

  ckv_calc u_calc (.data(in_data), .is_cmd(in_is_cmd), .expected(expected));

  ckv_lfsr #(.WIDTH(LFSR_W)) u_lfsr (.clk(clk), .rst_n(rst_n), .state(lfsr_state));

  assign in_ready  = rst_n;
  assign accept    = in_valid & in_ready & ~abort & ~frame_start;
  assign fault     = err_line | err_illegal | err_prot;
  assign set_abort = ~abort & ~frame_start & (fault | (accept & (expected != in_chk)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abort  <= 1'b0;
      chk_ok <= 1'b0;
    end else begin
      chk_ok <= accept & ~fault & (expected == in_chk);
      if (frame_start)    abort <= 1'b0;
      else if (set_abort) abort <= 1'b1;
    end
  end

  ckv_backoff #(.DELAY_BITS(DELAY_BITS), .MIN_WAIT(MIN_WAIT)) u_backoff (
    .clk(clk), .rst_n(rst_n), .start(set_abort), .cancel(frame_start),
    .rand_bits(lfsr_state[DELAY_BITS-1:0]), .done(backoff_done)
  );
endmodule

// File: rtl/ckv_verifier_sva.sv
module ckv_verifier_sva #(
  parameter int DELAY_BITS = 4,
  parameter int MIN_WAIT   = 2
) (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic err_line,
  input logic err_illegal,
  input logic err_prot,
  input logic frame_start,
  input logic chk_ok,
  input logic abort,
  input logic backoff_done
);
  localparam int MAXW = MIN_WAIT + (1 << DELAY_BITS) - 1;
  logic [7:0] since_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !abort) since_q <= '0;
    else if (since_q != 8'hFF) since_q <= since_q + 8'd1;
  end

  AST_OK_EXCLUDES_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ok |-> !abort); // R3
  AST_FAULT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_line || err_illegal || err_prot) && !frame_start) |=> abort); // R4
  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !frame_start) |=> abort); // R5
  AST_FRAME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!abort && !chk_ok && !backoff_done)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_done |=> !backoff_done); // R7
  AST_DONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_done |-> (abort && since_q >= 8'(MIN_WAIT) && since_q <= 8'(MAXW))); // R7
  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready); // R8
endmodule

bind ckv_verifier ckv_verifier_sva #(.DELAY_BITS(DELAY_BITS), .MIN_WAIT(MIN_WAIT)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .err_line(err_line),
  .err_illegal(err_illegal), .err_prot(err_prot), .frame_start(frame_start),
  .chk_ok(chk_ok), .abort(abort), .backoff_done(backoff_done)
);

// File: tb/ckv_verifier_tb.sv
module ckv_verifier_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_WAIT = 2;
  localparam int MAXW = 17;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_is_cmd = 0;
  logic [7:0] in_data = 0;
  logic [1:0] in_chk = 0;
  logic err_line = 0, err_illegal = 0, err_prot = 0, frame_start = 0;
  logic in_ready, chk_ok, abort, backoff_done;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ckv_verifier u_dut (.*);

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [1:0] exp_chk(input logic [7:0] d, input logic cmd);
    int n = 0;
    for (int i = 0; i < 8; i++) if (!(cmd && i < 2)) n += d[i];
    return {n[1], ~n[0]};
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // drive one beat, sample the cycle after its transfer edge
  task automatic beat(input logic [7:0] d, input logic [1:0] c, input logic cmd);
    @(negedge clk);
    in_valid = 1; in_data = d; in_chk = c; in_is_cmd = cmd;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic new_frame();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
  endtask

  task automatic t_reset();
    check("R8 ready in reset", in_ready, 1'b0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R9 abort", abort, 1'b0);
    check("R9 chk_ok", chk_ok, 1'b0);
    check("R9 backoff_done", backoff_done, 1'b0);
    check("R8 ready", in_ready, 1'b1);
  endtask

  task automatic t_data_ok();
    logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'h07, 8'h87, 8'h5C};
    foreach (pats[i]) begin
      beat(pats[i], exp_chk(pats[i], 1'b0), 1'b0);
      check("R1 data match ok", chk_ok, 1'b1);
      check("R1 no abort", abort, 1'b0);
      @(negedge clk);
      check("R1 ok single cycle", chk_ok, 1'b0);
    end
    check("R1 0x00 field", exp_chk(8'h00, 1'b0) == 2'b01, 1'b1);
  endtask

  task automatic t_cmd_ok();
    // 0x87 as command: bits 7:2 hold two ones -> 11; low bits ignored
    beat(8'h87, 2'b11, 1'b1);
    check("R2 cmd 0x87 ok", chk_ok, 1'b1);
    beat(8'h03, 2'b01, 1'b1);
    check("R2 cmd 0x03 ok", chk_ok, 1'b1);
    check("R2 no abort", abort, 1'b0);
  endtask

  task automatic t_mismatch();
    beat(8'h87, 2'b01, 1'b1);  // data-style field on a command word
    check("R3 chk_ok low", chk_ok, 1'b0);
    check("R3 abort", abort, 1'b1);
  endtask

  task automatic t_backoff();
    int k = 0;
    while (k < MAXW + 4 && !backoff_done) begin
      @(negedge clk); k++;
    end
    check("R7 done seen", backoff_done, 1'b1);
    check("R7 window", (k >= MIN_WAIT && k <= MAXW), 1'b1);
    @(negedge clk);
    check("R7 single pulse", backoff_done, 1'b0);
  endtask

  task automatic t_sticky();
    beat(8'h00, 2'b01, 1'b0);
    check("R5 ignored beat", chk_ok, 1'b0);
    check("R5 still aborted", abort, 1'b1);
    new_frame();
    check("R6 abort cleared", abort, 1'b0);
    beat(8'h00, 2'b01, 1'b0);
    check("R6 accepts after frame", chk_ok, 1'b1);
  endtask

  task automatic t_err(input int which);
    @(negedge clk);
    in_valid = 1; in_data = 8'hFF; in_chk = 2'b01; in_is_cmd = 0;
    err_line = (which == 0); err_illegal = (which == 1); err_prot = (which == 2);
    @(negedge clk);
    in_valid = 0; err_line = 0; err_illegal = 0; err_prot = 0;
    check("R4 abort on fault", abort, 1'b1);
    check("R4 no ok with fault", chk_ok, 1'b0);
    t_backoff();
    new_frame();
  endtask

  task automatic t_frame_same_edge();
    @(negedge clk);
    frame_start = 1; in_valid = 1; in_data = 8'h00; in_chk = 2'b01; in_is_cmd = 0;
    @(negedge clk);
    frame_start = 0; in_valid = 0;
    check("R6 beat dropped", chk_ok, 1'b0);
    check("R6 no abort", abort, 1'b0);
  endtask

  task automatic t_cancel();
    logic seen = 0;
    beat(8'h00, 2'b00, 1'b0);
    check("R3 abort before cancel", abort, 1'b1);
    new_frame();
    for (int i = 0; i < MAXW + 4; i++) begin
      @(negedge clk);
      if (backoff_done) seen = 1;
    end
    check("R6 backoff cancelled", seen, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_data_ok();
    t_cmd_ok();
    t_mismatch();
    t_backoff();
    t_sticky();
    for (int w = 0; w < 3; w++) begin
      repeat (w * 3 + 1) @(negedge clk);
      t_err(w);
    end
    t_frame_same_edge();
    t_cancel();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule